// File: doc/BRIEF.md
# Cycle-by-Cycle Peak Current Limiter

This block sits between the PWM request of a motor drive and the gate of the high-side, PWM-switched output device. It enforces a peak-current limit one switching period at a time. A free-running internal period timer sets the rate at which limiting acts. A digital over-current comparator bit is watched while the high side conducts. Right after each high-side turn-on the bit is ignored for a blanking window, so that the reverse-recovery spike of the freewheeling diode does not count as an over-current.

Once an over-current is qualified, the block latches a trip. The trip gates the requested PWM off, which shortens the on-time for the rest of that internal period. The trip releases at the next period boundary. After that, the next turn-on passes through a fresh blanking window. Commutation and the low-side devices are not touched: only the high-side on-signal is gated. A sticky status bit records that at least one trip has happened. A dedicated clear input resets that bit.

Top module: `cbc_limiter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, no trip is latched, `trip_seen_o` is 0 and `hs_on_o` equals `pwm_req_i`.
- R2: With no latched trip, `hs_on_o` equals `pwm_req_i` in the same cycle (combinational pass-through).
- R3: On every high-side turn-on (a cycle where `hs_on_o` is 1 after being 0), `oc_i` is ignored during the turn-on cycle and the `BLANK_CLKS - 1` cycles after it. This holds for every turn-on, including pulses shorter than the window.
- R4: An over-current is qualified in a cycle where `hs_on_o` is 1, blanking has ended and `oc_i` is 1. From the next cycle until the current internal period ends, `hs_on_o` is 0, whatever `pwm_req_i` and `oc_i` do.
- R5: `trip_seen_o` becomes 1 in the cycle after a qualified over-current. It stays 1 until `clr_i` is sampled high, and reads 0 in the cycle after that clear.
- R6: The internal period is `PERIOD_CLKS` cycles long. Number the cycles by the count of rising clock edges since reset release. Each period then starts at a multiple of `PERIOD_CLKS`. A latched trip is released in the first cycle of the next period, and `hs_on_o` follows `pwm_req_i` again from that cycle. The turn-on that follows passes through a new blanking window.
- R7: `oc_i` has no effect while `hs_on_o` is 0. It neither latches a trip nor sets `trip_seen_o`.
- R8: An over-current qualified in the last cycle of a period does not gate the next period. `hs_on_o` follows `pwm_req_i` from the first cycle of that period, but `trip_seen_o` is still set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwm_req_i | input | 1 | Requested high-side on-signal, 1 = on |
| oc_i | input | 1 | Over-current comparator bit, 1 = above limit |
| clr_i | input | 1 | Clears the sticky trip status |
| hs_on_o | output | 1 | Gated high-side on-signal |
| trip_seen_o | output | 1 | Sticky flag: a limit trip has occurred |

## Verification
The gated output follows the request in the same cycle. A qualified over-current takes that output low one cycle later, and the sticky flag rises in that same later cycle. The bench numbers every cycle by the rising edges counted since reset release, so it knows where each period and each blanking window starts and ends. It applies stimulus at a falling edge, and samples the combinational output shortly after that edge. The sticky flag it samples one falling edge after the stimulus. Each boundary case is placed on an exact cycle index: the last ignored blanking cycle, the first qualifying cycle, the last cycle of a period and the first cycle of the next.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

    // State held by the trip latch: the per-period gate and the sticky record.
    typedef struct packed {
        logic tripped;
        logic seen;
    } lim_flags_t;

    // Width for a counter that must hold values 0..max_val.
    function automatic int unsigned cnt_width(input int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/cbc_period_timer.sv
module cbc_period_timer #(
    parameter int unsigned PERIOD_CLKS = 200
) (
    input  logic clk,
    input  logic rst_n,
    output logic period_end_o
);
    localparam int unsigned CNT_W = cbc_pkg::cnt_width(PERIOD_CLKS - 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CLKS - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign period_end_o = (st_q.cnt == LAST);

endmodule

// File: rtl/cbc_blank_timer.sv
module cbc_blank_timer #(
    parameter int unsigned BLANK_CLKS = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hs_on_i,
    output logic done_o
);
    localparam int unsigned BLK_W = cbc_pkg::cnt_width(BLANK_CLKS);
    localparam logic [BLK_W-1:0] FULL = BLK_W'(BLANK_CLKS);

    typedef struct packed {
        logic [BLK_W-1:0] cnt;
    } blk_st_t;

    blk_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!hs_on_i) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != FULL) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o = (st_q.cnt == FULL);

endmodule

// File: rtl/cbc_trip_latch.sv
module cbc_trip_latch
    import cbc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_req_i,
    input  logic oc_i,
    input  logic blank_done_i,
    input  logic period_end_i,
    input  logic clr_i,
    output logic hs_on_o,
    output logic tripped_o,
    output logic seen_o
);
    lim_flags_t st_d, st_q;
    logic       qualify;

    assign hs_on_o = pwm_req_i & ~st_q.tripped;
    assign qualify = hs_on_o & blank_done_i & oc_i;

    always_comb begin
        st_d = st_q;
        if (period_end_i) begin
            st_d.tripped = 1'b0;
        end else if (qualify) begin
            st_d.tripped = 1'b1;
        end
        if (qualify) begin
            st_d.seen = 1'b1;
        end else if (clr_i) begin
            st_d.seen = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tripped_o = st_q.tripped;
    assign seen_o    = st_q.seen;

endmodule

// File: rtl/cbc_limiter.sv
module cbc_limiter #(
    parameter int unsigned PERIOD_CLKS = 200,
    parameter int unsigned BLANK_CLKS  = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_req_i,
    input  logic oc_i,
    input  logic clr_i,
    output logic hs_on_o,
    output logic trip_seen_o
);
    logic period_end;
    logic blank_done;
    logic tripped;

    cbc_period_timer #(
        .PERIOD_CLKS(PERIOD_CLKS)
    ) u_period (
        .clk          (clk),
        .rst_n        (rst_n),
        .period_end_o (period_end)
    );

    cbc_blank_timer #(
        .BLANK_CLKS(BLANK_CLKS)
    ) u_blank (
        .clk     (clk),
        .rst_n   (rst_n),
        .hs_on_i (hs_on_o),
        .done_o  (blank_done)
    );

    cbc_trip_latch u_latch (
        .clk          (clk),
        .rst_n        (rst_n),
        .pwm_req_i    (pwm_req_i),
        .oc_i         (oc_i),
        .blank_done_i (blank_done),
        .period_end_i (period_end),
        .clr_i        (clr_i),
        .hs_on_o      (hs_on_o),
        .tripped_o    (tripped),
        .seen_o       (trip_seen_o)
    );

endmodule

// File: rtl/cbc_limiter_chk.sv
module cbc_limiter_chk (
    input logic clk,
    input logic rst_n,
    input logic pwm_req_i,
    input logic oc_i,
    input logic clr_i,
    input logic hs_on_o,
    input logic trip_seen_o,
    input logic tripped,
    input logic blank_done,
    input logic period_end
);
    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
        end
    end

    // R2
    req_low_gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_req_i |-> !hs_on_o);

    // R3
    turn_on_blanked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && hs_on_o && !$past(hs_on_o)) |-> !blank_done);

    // R4
    qualified_cuts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_on_o && blank_done && oc_i && !period_end) |=> !hs_on_o);

    // R4
    gate_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_req_i && !hs_on_o && !period_end) |=> !hs_on_o);

    // R5
    sticky_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_seen_o && !clr_i) |=> trip_seen_o);

    // R5
    sticky_on_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(tripped)) |-> trip_seen_o);

    // R6
    boundary_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_end |=> (hs_on_o == pwm_req_i));

    // R7
    off_ignores_oc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hs_on_o && !trip_seen_o && !tripped) |=> !trip_seen_o);

endmodule

bind cbc_limiter cbc_limiter_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwm_req_i   (pwm_req_i),
    .oc_i        (oc_i),
    .clr_i       (clr_i),
    .hs_on_o     (hs_on_o),
    .trip_seen_o (trip_seen_o),
    .tripped     (tripped),
    .blank_done  (blank_done),
    .period_end  (period_end)
);

// File: tb/cbc_limiter_test.sv
`timescale 1ns/1ps
module cbc_limiter_test;
    localparam int P = 40;
    localparam int B = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwm_req_i = 1'b0;
    logic oc_i = 1'b0;
    logic clr_i = 1'b0;
    logic hs_on_o;
    logic trip_seen_o;

    int checks = 0;
    int errors = 0;
    int edges = 0;

    always #4 clk = ~clk;

    always @(posedge clk) if (rst_n) edges <= edges + 1;

    cbc_limiter #(.PERIOD_CLKS(P), .BLANK_CLKS(B)) uut (
        .clk(clk), .rst_n(rst_n), .pwm_req_i(pwm_req_i), .oc_i(oc_i),
        .clr_i(clr_i), .hs_on_o(hs_on_o), .trip_seen_o(trip_seen_o)
    );

    task automatic check(input logic got, input logic exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b (cycle %0d)", tag, got, exp, edges % P);
        end
    endtask

    // Advance to the falling edge inside the cycle whose index mod P is v.
    task automatic wait_cnt(input int v);
        @(negedge clk);
        while ((edges % P) != v) @(negedge clk);
    endtask

    task automatic t_reset();
        pwm_req_i = 1'b1;
        #1;
        check(hs_on_o, 1'b1, "R1 gate follows request in reset");
        check(trip_seen_o, 1'b0, "R1 sticky clear in reset");
        pwm_req_i = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(hs_on_o, 1'b0, "R1 gate low after reset");
        check(trip_seen_o, 1'b0, "R1 sticky clear after reset");
    endtask

    task automatic t_pass();
        wait_cnt(2); pwm_req_i = 1'b1; #1; check(hs_on_o, 1'b1, "R2 pass high");
        wait_cnt(3); pwm_req_i = 1'b0; #1; check(hs_on_o, 1'b0, "R2 pass low");
        wait_cnt(4); pwm_req_i = 1'b1; #1; check(hs_on_o, 1'b1, "R2 pass high again");
        wait_cnt(5); pwm_req_i = 1'b0; #1; check(hs_on_o, 1'b0, "R2 pass low again");
    endtask

    task automatic t_blank();
        wait_cnt(P - 1); pwm_req_i = 1'b0; oc_i = 1'b0;
        wait_cnt(0); pwm_req_i = 1'b1; oc_i = 1'b1;
        for (int i = 1; i < B; i++) begin
            wait_cnt(i); #1; check(hs_on_o, 1'b1, "R3 over-current blanked");
        end
        wait_cnt(B); oc_i = 1'b0; #1; check(hs_on_o, 1'b1, "R3 end of window");
        wait_cnt(B + 2); #1;
        check(hs_on_o, 1'b1, "R3 no trip from blanked pulse");
        check(trip_seen_o, 1'b0, "R3 sticky untouched by blanked pulse");
        wait_cnt(12); pwm_req_i = 1'b0;
        wait_cnt(14); pwm_req_i = 1'b1; oc_i = 1'b1;
        wait_cnt(14 + B); oc_i = 1'b0;
        wait_cnt(21); #1;
        check(hs_on_o, 1'b1, "R3 second turn-on re-blanked");
        check(trip_seen_o, 1'b0, "R3 sticky after second turn-on");
    endtask

    task automatic t_trip();
        wait_cnt(24); oc_i = 1'b1;
        wait_cnt(25); oc_i = 1'b0; #1;
        check(hs_on_o, 1'b0, "R4 gate cut next cycle");
        @(negedge clk); #1;
        check(trip_seen_o, 1'b1, "R5 sticky set after trip");
        wait_cnt(P - 1); #1;
        check(hs_on_o, 1'b0, "R4 gate held to period end");
        wait_cnt(0); #1;
        check(hs_on_o, 1'b1, "R6 release at period start");
        check(trip_seen_o, 1'b1, "R5 sticky survives release");
    endtask

    task automatic t_clear();
        wait_cnt(2); clr_i = 1'b1;
        wait_cnt(3); clr_i = 1'b0; #1;
        check(trip_seen_o, 1'b0, "R5 sticky cleared");
    endtask

    task automatic t_reblank();
        wait_cnt(8); oc_i = 1'b1;
        wait_cnt(9); #1; check(hs_on_o, 1'b0, "R4 trip with held over-current");
        wait_cnt(0);
        for (int i = 0; i <= B; i++) begin
            if (i > 0) wait_cnt(i);
            #1; check(hs_on_o, 1'b1, "R6 new window after release");
        end
        wait_cnt(B + 1); #1; check(hs_on_o, 1'b0, "R6 trip once window ends");
        oc_i = 1'b0;
    endtask

    task automatic t_edge();
        wait_cnt(2); clr_i = 1'b1;
        wait_cnt(3); clr_i = 1'b0; #1;
        check(trip_seen_o, 1'b0, "R5 sticky cleared while gated");
        wait_cnt(0);
        wait_cnt(P - 1); oc_i = 1'b1; #1;
        check(hs_on_o, 1'b1, "R8 on in last cycle");
        wait_cnt(0); oc_i = 1'b0; #1;
        check(hs_on_o, 1'b1, "R8 next period not gated");
        wait_cnt(1); #1;
        check(hs_on_o, 1'b1, "R8 still on");
        check(trip_seen_o, 1'b1, "R8 sticky records late trip");
    endtask

    task automatic t_off();
        wait_cnt(2); clr_i = 1'b1;
        wait_cnt(3); clr_i = 1'b0; pwm_req_i = 1'b0; oc_i = 1'b1;
        wait_cnt(20); #1; check(hs_on_o, 1'b0, "R7 off while requested off");
        wait_cnt(6); oc_i = 1'b0; pwm_req_i = 1'b1;
        wait_cnt(7); #1;
        check(hs_on_o, 1'b1, "R7 no trip from over-current while off");
        check(trip_seen_o, 1'b0, "R7 sticky untouched while off");
        pwm_req_i = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_pass();
        t_blank();
        t_trip();
        t_clear();
        t_reblank();
        t_edge();
        t_off();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule